// File: doc/BRIEF.md
# Five-Stage 16-bit Pipelined Processor Core

This block is a small in-order processor core. Instructions are 16 bits wide. A new instruction is fetched every cycle and passes through fetch, decode, execute, memory and write-back stages. Each instruction's top three bits pick one of eight operations. The decoder turns that choice into an 11-bit control word, which travels down the pipeline with the instruction. The core reads instructions from an asynchronous instruction memory port. It reaches an 8K-word data memory through one asynchronous read/write port.

Loads and stores carry a 13-bit absolute address. Data always passes through two fixed registers: a load lands in register 7, and a store writes out register 8. Jumps also use a 13-bit absolute target. Branches compare two registers and move the program counter by a 6-bit word offset, forward or backward from the branch's own address.

Branches and jumps resolve in execute. The two instructions behind them always run. The core has no interlocks and no forwarding, so the program must place independent instructions or nops between dependent ones. A halt instruction stops fetching and raises a sticky halted flag once it retires.

Top module: `pipe16_core`

## Requirements
- R1: While reset is held, the fetch address is 0, the data read and write strobes are low, and halted is low.
- R2: Opcode 001 is arithmetic. The destination register is in bits [12:9] and can name any of the 16 registers. The sources are in bits [8:6] and [5:3] and reach registers 0 to 7. The function is in bits [1:0]: 00 add, 01 subtract, 10 AND, 11 OR. Results wrap modulo 2^16.
- R3: Register 0 always reads as zero. An arithmetic result aimed at register 0 is discarded.
- R4: Opcode 011 loads the data word at address bits [12:0] into register 7. Each load raises the data read strobe for exactly one cycle, and no other instruction raises it.
- R5: Opcode 100 writes the contents of register 8 to data address bits [12:0]. Each store raises the data write strobe for exactly one cycle.
- R6: Opcode 010 jumps to the absolute address in bits [12:0]. The two instructions that follow the jump in memory still execute, and the target instruction runs next.
- R7: Opcode 101 branches when two registers are equal, and opcode 110 branches when they differ. The registers are in bits [12:10] and [9:7]. Bit 6 set means a backward move (branch address minus offset), clear means forward (plus offset). The offset is in bits [5:0]. The two instructions that follow the branch always execute.
- R8: Opcode 111 halts. The instruction after the halt does not execute, the fetch address holds at the halt's address plus one, and halted rises and stays high until reset.
- R9: A register written by one instruction can be read by the third instruction after it, meaning two intervening instructions are enough.
- R10: Opcode 000 (the all-zero word) is a nop. It writes no register and raises no data strobe.

Ports are listed in the order of the top module's port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | 13 | Instruction fetch address |
| imem_data_i | input | 16 | Instruction word at the fetch address (same cycle) |
| dmem_addr_o | output | 13 | Data memory word address |
| dmem_wdata_o | output | 16 | Store data |
| dmem_we_o | output | 1 | Data write strobe |
| dmem_re_o | output | 1 | Data read strobe |
| dmem_rdata_i | input | 16 | Load data at the data address (same cycle) |
| halted_o | output | 1 | Set once a halt has retired |

## Verification
The only visible results are data memory writes. A scoreboard therefore holds the ordered (address, value) pairs that each program must store, and every register result is moved into register 8 and stored. One program computes all four arithmetic functions on two loaded operands whose bits overlap only in part, so that add, subtract, AND and OR each give a different word. The same program includes a negative subtraction and writes aimed at register 0. A control-flow program uses taken and untaken branches of both kinds, a jump whose delay slot produces the stored value, and a backward branch that runs a loop body twice. The code placed after a taken branch stores to an address nobody expects, so a branch that falls through shows up as an unexpected write. Further programs place stores right behind a halt and run a stretch of nops, which separates "stops at once" from "stops late" and shows that nops touch nothing.

// File: rtl/pipe16_pkg.sv
package pipe16_pkg;

    localparam int INSTR_W = 16;
    localparam int OPC_W   = 3;

    typedef enum logic [OPC_W-1:0] {
        OPC_NOP = 3'd0,
        OPC_ALU = 3'd1,
        OPC_JMP = 3'd2,
        OPC_LDW = 3'd3,
        OPC_STW = 3'd4,
        OPC_BEQ = 3'd5,
        OPC_BNE = 3'd6,
        OPC_HLT = 3'd7
    } opc_e;

    typedef enum logic [1:0] {
        FN_ADD = 2'd0,
        FN_SUB = 2'd1,
        FN_AND = 2'd2,
        FN_OR  = 2'd3
    } alu_fn_e;

    // 11-bit control word, most significant field first
    typedef struct packed {
        logic jump;     // 10
        logic br_eq;    // 9
        logic mem_rd;   // 8
        logic mem_wr;   // 7
        logic st_src;   // 6 second read port takes the store register
        logic wb_mem;   // 5 write-back data comes from memory
        logic br_ne;    // 4
        logic reg_wr;   // 3
        logic pc_wr;    // 2 low only for halt
        logic branch;   // 1
        logic ld_dst;   // 0 destination is the load register
    } ctrl_t;

    localparam ctrl_t CTRL_NOP = ctrl_t'(11'b000_0000_0100);

endpackage

// File: rtl/p16_ctrl.sv
module p16_ctrl
    import pipe16_pkg::*;
(
    input  logic [OPC_W-1:0] opc_i,
    output ctrl_t            ctrl_o
);

    always_comb begin
        ctrl_o = CTRL_NOP;
        case (opc_i)
            OPC_ALU: begin
                ctrl_o.reg_wr = 1'b1;
            end
            OPC_JMP: begin
                ctrl_o.jump = 1'b1;
            end
            OPC_LDW: begin
                ctrl_o.mem_rd = 1'b1;
                ctrl_o.wb_mem = 1'b1;
                ctrl_o.reg_wr = 1'b1;
                ctrl_o.ld_dst = 1'b1;
            end
            OPC_STW: begin
                ctrl_o.mem_wr = 1'b1;
                ctrl_o.st_src = 1'b1;
            end
            OPC_BEQ: begin
                ctrl_o.br_eq  = 1'b1;
                ctrl_o.branch = 1'b1;
            end
            OPC_BNE: begin
                ctrl_o.br_ne  = 1'b1;
                ctrl_o.branch = 1'b1;
            end
            OPC_HLT: begin
                ctrl_o.pc_wr = 1'b0;
            end
            default: ctrl_o = CTRL_NOP;
        endcase
    end

endmodule

// File: rtl/p16_alu.sv
module p16_alu
    import pipe16_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_fn_e           fn_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] y_o
);

    always_comb begin
        case (fn_i)
            FN_ADD:  y_o = a_i + b_i;
            FN_SUB:  y_o = a_i - b_i;
            FN_AND:  y_o = a_i & b_i;
            FN_OR:   y_o = a_i | b_i;
            default: y_o = '0;
        endcase
    end

endmodule

// File: rtl/p16_regfile.sv
module p16_regfile #(
    parameter int DATA_W = 16,
    parameter int NREG   = 16,
    localparam int RA_W  = $clog2(NREG)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [RA_W-1:0]   waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [RA_W-1:0]   raddr_a_i,
    input  logic [RA_W-1:0]   raddr_b_i,
    output logic [DATA_W-1:0] rdata_a_o,
    output logic [DATA_W-1:0] rdata_b_o
);

    logic [DATA_W-1:0] regs_q [NREG];
    logic [DATA_W-1:0] regs_d [NREG];

    always_comb begin
        regs_d = regs_q;
        if (we_i && (waddr_i != '0)) begin
            regs_d[waddr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    // reads see a write made in the same cycle
    assign rdata_a_o = (raddr_a_i == '0) ? '0 : regs_d[raddr_a_i];
    assign rdata_b_o = (raddr_b_i == '0) ? '0 : regs_d[raddr_b_i];

    AST_ZERO_REG_STAYS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        regs_q[0] == '0); // R3

    AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && (waddr_i != '0)) |=> (regs_q[$past(waddr_i)] == $past(wdata_i))); // R9

endmodule

// File: rtl/pipe16_core.sv
module pipe16_core
    import pipe16_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 13,
    parameter int NREG      = 16,
    parameter int LOAD_REG  = 7,
    parameter int STORE_REG = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    output logic [ADDR_W-1:0]    imem_addr_o,
    input  logic [INSTR_W-1:0]   imem_data_i,
    output logic [ADDR_W-1:0]    dmem_addr_o,
    output logic [DATA_W-1:0]    dmem_wdata_o,
    output logic                 dmem_we_o,
    output logic                 dmem_re_o,
    input  logic [DATA_W-1:0]    dmem_rdata_i,
    output logic                 halted_o
);

    localparam int RA_W  = $clog2(NREG);
    localparam int OFF_W = 6;

    typedef struct packed {
        logic [ADDR_W-1:0]  pc;
        logic [INSTR_W-1:0] ir;
    } ifid_t;

    typedef struct packed {
        ctrl_t              ctrl;
        logic [ADDR_W-1:0]  pc;
        logic [RA_W-1:0]    wa;
        logic [DATA_W-1:0]  a;
        logic [DATA_W-1:0]  b;
        alu_fn_e            fn;
        logic               back;
        logic [OFF_W-1:0]   off;
        logic [ADDR_W-1:0]  abs;
    } idex_t;

    typedef struct packed {
        ctrl_t              ctrl;
        logic [RA_W-1:0]    wa;
        logic [DATA_W-1:0]  res;
        logic [DATA_W-1:0]  sdat;
        logic [ADDR_W-1:0]  addr;
    } exmem_t;

    typedef struct packed {
        ctrl_t              ctrl;
        logic [RA_W-1:0]    wa;
        logic [DATA_W-1:0]  res;
        logic [DATA_W-1:0]  ld;
    } memwb_t;

    typedef struct packed {
        logic [ADDR_W-1:0]  pc;
        logic               stop;
        logic               halted;
        ifid_t              ifid;
        idex_t              idex;
        exmem_t             exmem;
        memwb_t             memwb;
    } core_t;

    function automatic core_t reset_state();
        core_t r;
        r            = '0;
        r.idex.ctrl  = CTRL_NOP;
        r.exmem.ctrl = CTRL_NOP;
        r.memwb.ctrl = CTRL_NOP;
        return r;
    endfunction

    core_t s_q, s_d;

    ctrl_t             id_ctrl;
    logic [RA_W-1:0]   id_ra, id_rb, id_wa;
    logic [DATA_W-1:0] id_a, id_b;
    logic [DATA_W-1:0] wb_data;
    logic [DATA_W-1:0] ex_res;
    logic              ex_eq, ex_take, redirect, stop;
    logic [ADDR_W-1:0] target;

    // ---------------- decode helpers ----------------
    p16_ctrl u_ctrl (
        .opc_i  (s_q.ifid.ir[15:13]),
        .ctrl_o (id_ctrl)
    );

    always_comb begin
        id_ra = id_ctrl.branch ? RA_W'(s_q.ifid.ir[12:10]) : RA_W'(s_q.ifid.ir[8:6]);
        if (id_ctrl.st_src) begin
            id_rb = RA_W'(STORE_REG);
        end else if (id_ctrl.branch) begin
            id_rb = RA_W'(s_q.ifid.ir[9:7]);
        end else begin
            id_rb = RA_W'(s_q.ifid.ir[5:3]);
        end
        id_wa   = id_ctrl.ld_dst ? RA_W'(LOAD_REG) : RA_W'(s_q.ifid.ir[12:9]);
        wb_data = s_q.memwb.ctrl.wb_mem ? s_q.memwb.ld : s_q.memwb.res;
    end

    p16_regfile #(
        .DATA_W (DATA_W),
        .NREG   (NREG)
    ) u_rf (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .we_i      (s_q.memwb.ctrl.reg_wr),
        .waddr_i   (s_q.memwb.wa),
        .wdata_i   (wb_data),
        .raddr_a_i (id_ra),
        .raddr_b_i (id_rb),
        .rdata_a_o (id_a),
        .rdata_b_o (id_b)
    );

    p16_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .fn_i (s_q.idex.fn),
        .a_i  (s_q.idex.a),
        .b_i  (s_q.idex.b),
        .y_o  (ex_res)
    );

    // ---------------- next-state logic ----------------
    always_comb begin
        s_d = s_q;

        // execute: branch and jump resolution
        ex_eq    = (s_q.idex.a == s_q.idex.b);
        ex_take  = s_q.idex.ctrl.branch &
                   ((s_q.idex.ctrl.br_eq & ex_eq) | (s_q.idex.ctrl.br_ne & ~ex_eq));
        redirect = ex_take | s_q.idex.ctrl.jump;
        if (s_q.idex.ctrl.jump) begin
            target = s_q.idex.abs;
        end else if (s_q.idex.back) begin
            target = s_q.idex.pc - ADDR_W'(s_q.idex.off);
        end else begin
            target = s_q.idex.pc + ADDR_W'(s_q.idex.off);
        end

        // halt seen in decode freezes fetch from now on
        stop       = s_q.stop | ~id_ctrl.pc_wr;
        s_d.stop   = stop;
        s_d.halted = s_q.halted | ~s_q.memwb.ctrl.pc_wr;

        // fetch
        if (stop) begin
            s_d.ifid.pc = s_q.pc;
            s_d.ifid.ir = '0;
        end else begin
            s_d.pc      = redirect ? target : s_q.pc + 1'b1;
            s_d.ifid.pc = s_q.pc;
            s_d.ifid.ir = imem_data_i;
        end

        // decode -> execute
        s_d.idex.ctrl = id_ctrl;
        s_d.idex.pc   = s_q.ifid.pc;
        s_d.idex.wa   = id_wa;
        s_d.idex.a    = id_a;
        s_d.idex.b    = id_b;
        s_d.idex.fn   = alu_fn_e'(s_q.ifid.ir[1:0]);
        s_d.idex.back = s_q.ifid.ir[6];
        s_d.idex.off  = s_q.ifid.ir[OFF_W-1:0];
        s_d.idex.abs  = ADDR_W'(s_q.ifid.ir[12:0]);

        // execute -> memory
        s_d.exmem.ctrl = s_q.idex.ctrl;
        s_d.exmem.wa   = s_q.idex.wa;
        s_d.exmem.res  = ex_res;
        s_d.exmem.sdat = s_q.idex.b;
        s_d.exmem.addr = s_q.idex.abs;

        // memory -> write-back
        s_d.memwb.ctrl = s_q.exmem.ctrl;
        s_d.memwb.wa   = s_q.exmem.wa;
        s_d.memwb.res  = s_q.exmem.res;
        s_d.memwb.ld   = dmem_rdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= reset_state();
        end else begin
            s_q <= s_d;
        end
    end

    assign imem_addr_o  = s_q.pc;
    assign dmem_addr_o  = s_q.exmem.addr;
    assign dmem_wdata_o = s_q.exmem.sdat;
    assign dmem_we_o    = s_q.exmem.ctrl.mem_wr;
    assign dmem_re_o    = s_q.exmem.ctrl.mem_rd;
    assign halted_o     = s_q.halted;

    logic unused_state;
    assign unused_state = ^s_q;

    // ---------------- assertions ----------------
    AST_HALTED_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        halted_o |=> halted_o); // R8

    AST_FETCH_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop |=> $stable(imem_addr_o)); // R8

    AST_SEQ_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!redirect && !stop) |=> (imem_addr_o == $past(imem_addr_o) + 1'b1)); // R6

    AST_REDIRECT_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (redirect && !stop) |=> (imem_addr_o == $past(target))); // R7

    AST_ONE_FLOW_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({s_q.idex.ctrl.jump, s_q.idex.ctrl.br_eq, s_q.idex.ctrl.br_ne})); // R7

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(dmem_we_o && dmem_re_o)); // R4

    AST_LOAD_TO_LDREG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.memwb.ctrl.wb_mem && s_q.memwb.ctrl.reg_wr) |-> (s_q.memwb.wa == RA_W'(LOAD_REG))); // R4

endmodule

// File: tb/pipe16_core_tb_top.sv
module pipe16_core_tb_top;

    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] imem_addr;
    logic [15:0] imem_data;
    logic [12:0] dmem_addr;
    logic [15:0] dmem_wdata;
    logic        dmem_we;
    logic        dmem_re;
    logic [15:0] dmem_rdata;
    logic        halted;

    int n_chk  = 0;
    int n_bad  = 0;
    int re_cnt = 0;
    int pa     = 0;
    string cur_req = "R5";

    logic [15:0] prog [256];
    logic [28:0] exp_q [$];
    string       req_q [$];
    logic [28:0] mon_e;
    string       mon_r;

    always #10ns clk = ~clk;

    pipe16_core dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .imem_addr_o  (imem_addr),
        .imem_data_i  (imem_data),
        .dmem_addr_o  (dmem_addr),
        .dmem_wdata_o (dmem_wdata),
        .dmem_we_o    (dmem_we),
        .dmem_re_o    (dmem_re),
        .dmem_rdata_i (dmem_rdata),
        .halted_o     (halted)
    );

    function automatic logic [15:0] rom_word(input logic [12:0] a);
        if (a == 13'd100) return 16'h1234;
        if (a == 13'd101) return 16'h0F0F;
        return 16'hDEAD;
    endfunction

    assign imem_data  = prog[imem_addr[7:0]];
    assign dmem_rdata = rom_word(dmem_addr);

    // encoders written from the requirement field positions
    function automatic logic [15:0] f_alu(input int rd, input int rs, input int rt, input int fn);
        return {3'b001, 4'(rd), 3'(rs), 3'(rt), 1'b0, 2'(fn)};
    endfunction
    function automatic logic [15:0] f_br(input int op, input int ra, input int rb, input int back, input int off);
        return {3'(op), 3'(ra), 3'(rb), 1'(back), 6'(off)};
    endfunction
    function automatic logic [15:0] f_mem(input int op, input int addr);
        return {3'(op), 13'(addr)};
    endfunction
    localparam logic [15:0] NOP = 16'h0000;
    localparam logic [15:0] HLT = 16'hE000;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // driver side of the scoreboard
    task automatic expect_store(input int addr, input logic [15:0] data, input string req);
        exp_q.push_back({13'(addr), data});
        req_q.push_back(req);
    endtask

    task automatic put(input logic [15:0] w);
        prog[pa] = w;
        pa++;
    endtask
    task automatic sp(input logic [15:0] w);
        put(w); put(NOP); put(NOP);
    endtask
    task automatic store_reg(input int r, input int addr);
        sp(f_alu(8, r, 0, 0));
        sp(f_mem(4, addr));
    endtask

    task automatic begin_prog(input string req);
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) prog[i] = NOP;
        pa = 0;
        exp_q.delete();
        req_q.delete();
        re_cnt  = 0;
        cur_req = req;
    endtask

    task automatic run_prog(input int exp_reads, input string rd_req);
        int cyc;
        logic [12:0] haddr;
        repeat (2) @(negedge clk);
        check(imem_addr == 13'd0, "R1", "fetch address in reset", 32'(imem_addr), 0);
        check(!dmem_we && !dmem_re, "R1", "data strobes in reset", {dmem_we, dmem_re}, 0);
        check(!halted, "R1", "halted in reset", 32'(halted), 0);
        rst_n = 1'b1;
        cyc = 0;
        while (!halted && cyc < 4000) begin
            @(negedge clk);
            cyc++;
        end
        check(halted, "R8", "halted after program", 32'(halted), 1);
        haddr = imem_addr;
        repeat (6) @(negedge clk);
        check(imem_addr == haddr && halted, "R8", "fetch frozen while halted", 32'(imem_addr), 32'(haddr));
        check(exp_q.size() == 0, cur_req, "stores still outstanding", exp_q.size(), 0);
        check(re_cnt == exp_reads, rd_req, "load read strobes", re_cnt, exp_reads);
    endtask

    // monitor side of the scoreboard
    always @(negedge clk) begin
        if (rst_n && dmem_re) re_cnt++;
        if (rst_n && dmem_we) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL %s unexpected store: actual=%0d:%h expected=none",
                         cur_req, dmem_addr, dmem_wdata);
            end else begin
                mon_e = exp_q.pop_front();
                mon_r = req_q.pop_front();
                if ({dmem_addr, dmem_wdata} != mon_e) begin
                    n_bad++;
                    $display("FAIL %s store: actual=%0d:%h expected=%0d:%h",
                             mon_r, dmem_addr, dmem_wdata, mon_e[28:16], mon_e[15:0]);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=150000 cycles expected=program end");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int jpc, bpc, lp, hpc;

        // ---- arithmetic, register 0, load/store, spacing of two ----
        begin_prog("R2");
        sp(f_mem(3, 100));          // R4 r7 = 1234
        sp(f_alu(1, 7, 0, 0));      // r1 = r7 (R9: third instruction reads it)
        sp(f_mem(3, 101));
        sp(f_alu(2, 7, 0, 0));      // r2 = 0F0F
        sp(f_alu(8, 1, 2, 0)); sp(f_mem(4, 200)); expect_store(200, 16'h2143, "R2 add");
        sp(f_alu(8, 1, 2, 1)); sp(f_mem(4, 201)); expect_store(201, 16'h0325, "R2 sub");
        sp(f_alu(8, 1, 2, 2)); sp(f_mem(4, 202)); expect_store(202, 16'h0204, "R2 and");
        sp(f_alu(8, 1, 2, 3)); sp(f_mem(4, 203)); expect_store(203, 16'h1F3F, "R2 or");
        sp(f_alu(8, 2, 1, 1)); sp(f_mem(4, 206)); expect_store(206, 16'hFCDB, "R2 sub wrap");
        sp(f_alu(0, 1, 2, 3));      // R3 write to register 0 dropped
        sp(f_alu(8, 0, 1, 0)); sp(f_mem(4, 204)); expect_store(204, 16'h1234, "R3 r0+r1");
        sp(f_alu(8, 0, 0, 3)); sp(f_mem(4, 205)); expect_store(205, 16'h0000, "R3 r0 reads zero");
        put(f_alu(3, 1, 0, 0)); put(NOP); put(NOP);
        put(f_alu(8, 3, 0, 0)); put(NOP); put(NOP);   // R9 exactly two between
        put(f_mem(4, 207)); expect_store(207, 16'h1234, "R9 spacing");
        put(HLT);
        run_prog(2, "R4");

        // ---- jump, branches, delay slots ----
        begin_prog("R7");
        sp(f_mem(3, 100)); sp(f_alu(1, 7, 0, 0));
        sp(f_mem(3, 101)); sp(f_alu(2, 7, 0, 0));
        sp(f_alu(3, 1, 0, 0));
        jpc = pa; put(NOP);
        put(f_alu(8, 2, 0, 0)); put(NOP);             // R6 delay slots run
        store_reg(0, 399);                             // skipped
        prog[jpc] = f_mem(2, pa);
        put(NOP); sp(f_mem(4, 302)); expect_store(302, 16'h0F0F, "R6 jump slot");
        bpc = pa; put(NOP); put(NOP); put(NOP);
        store_reg(0, 398);
        prog[bpc] = f_br(5, 1, 3, 0, pa - bpc);        // beq taken forward
        store_reg(1, 303); expect_store(303, 16'h1234, "R7 beq taken");
        put(f_br(5, 1, 2, 0, 40)); put(NOP); put(NOP); // beq not taken
        store_reg(2, 304); expect_store(304, 16'h0F0F, "R7 beq fall");
        bpc = pa; put(NOP); put(NOP); put(NOP);
        store_reg(0, 397);
        prog[bpc] = f_br(6, 1, 2, 0, pa - bpc);        // bne taken forward
        store_reg(1, 307); expect_store(307, 16'h1234, "R7 bne taken");
        put(f_br(6, 1, 3, 0, 40)); put(NOP); put(NOP); // bne not taken
        store_reg(3, 308); expect_store(308, 16'h1234, "R7 bne fall");
        sp(f_alu(4, 1, 0, 0)); sp(f_alu(8, 1, 0, 0));
        lp = pa;
        sp(f_mem(4, 305)); sp(f_alu(8, 2, 0, 0));
        put(f_br(6, 4, 0, 1, pa - lp));                // backward
        put(f_alu(4, 0, 0, 0)); put(NOP);
        sp(f_mem(4, 306));
        expect_store(305, 16'h1234, "R7 loop pass 1");
        expect_store(305, 16'h0F0F, "R7 loop pass 2");
        expect_store(306, 16'h0F0F, "R7 loop exit");
        put(HLT);
        run_prog(2, "R4");

        // ---- halt ----
        begin_prog("R8");
        sp(f_mem(3, 100)); sp(f_alu(8, 7, 0, 0));
        sp(f_mem(4, 402)); expect_store(402, 16'h1234, "R5 before halt");
        hpc = pa; put(HLT);
        put(f_mem(4, 400)); put(f_mem(4, 401));
        run_prog(1, "R4");
        check(imem_addr == 13'(hpc + 1), "R8", "frozen fetch address", 32'(imem_addr), hpc + 1);

        // ---- nops only ----
        begin_prog("R10");
        for (int i = 0; i < 20; i++) put(NOP);
        put(HLT);
        run_prog(0, "R10");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule